// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Core

This block sits between interrupt sources and one processor. It keeps three per-vector bitmaps over the vector space: requests waiting to be taken (pending), vectors being serviced (in-service) and, per vector, whether the last request was level or edge triggered. Software sets a task priority to hold back low classes. The block derives a processor priority from that value and from the highest vector in service. A single request line tells the processor whether a pending vector outranks that priority.

The processor takes an interrupt with an acknowledge strobe. In the same cycle `ack_vec` presents the vector it receives. At the clock edge that vector moves from pending to in-service. If the task priority holds the request back, the block returns the configured spurious vector instead and changes no state. An end-of-interrupt strobe retires the highest vector in service. A query port reads the three bitmap bits of any one vector.

The block has no sequential controller beyond its registers. Every operation completes in the clock edge that follows its strobe. The request line, acknowledge vector and processor priority are combinational functions of the registered state.

Top module: `irq_accept_core`

## Requirements
- R1: A set strobe marks `set_vec` pending. It writes that vector's trigger bit from `set_level`: 1 means level, 0 means edge. The bits read back on `qry_pend` and `qry_level` from the next cycle.
- R2: The highest-priority pending vector is the highest-numbered pending bit. A normal acknowledge returns it.
- R3: `irq` is high only while bit 8 of the spurious register (software enable) is 1 and at least one vector is pending.
- R4: `irq` stays low when `ppr` is nonzero and bits 7:4 of the highest pending vector are less than or equal to bits 7:4 of `ppr`.
- R5: When the task priority is nonzero and the highest pending vector is less than or equal to it, `ack_vec` shows bits 7:0 of the spurious register. An acknowledge in that state changes no bitmap.
- R6: With nothing pending, or with software enable 0, `ack_vec` also shows the spurious vector. An acknowledge then has no effect.
- R7: Otherwise an acknowledge clears that vector's pending bit and sets its in-service bit at the next edge.
- R8: End-of-interrupt clears only the highest-numbered in-service bit. With nothing in service it changes nothing.
- R9: A short task-priority write stores its 4-bit value in bits 7:4 and zeros bits 3:0. `tpr_short` returns bits 7:4.
- R10: `ppr` equals the task priority when nothing is in service, or when the task-priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise `ppr` is that vector with bits 3:0 cleared.
- R11: After reset all three bitmaps are clear, the task priority is 0 and the spurious register is 0x0FF. As a result `irq` is 0, `ppr` is 0 and `ack_vec` is 0xFF.
- R12: Operations in one cycle apply in this order: end-of-interrupt, acknowledge, set. A set of the vector being acknowledged leaves it both pending and in service. A full task-priority write overrides a short one in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_stb | input | 1 | Request strobe for `set_vec` |
| set_vec | input | 8 | Vector to mark pending |
| set_level | input | 1 | Trigger of the request: 1 level, 0 edge |
| ack_stb | input | 1 | Processor acknowledge strobe |
| eoi_stb | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Full task-priority write strobe |
| tpr_wdata | input | 8 | Full task-priority value |
| tpr_short_wr | input | 1 | Short task-priority write strobe |
| tpr_short_wdata | input | 4 | Short task-priority class |
| svr_wr | input | 1 | Spurious register write strobe |
| svr_wdata | input | 9 | Bit 8 software enable, bits 7:0 spurious vector |
| qry_vec | input | 8 | Vector whose bitmap bits are read back |
| irq | output | 1 | Interrupt request to the processor |
| ack_vec | output | 8 | Vector delivered by an acknowledge in this cycle |
| ppr | output | 8 | Processor priority |
| tpr_short | output | 4 | Task priority bits 7:4 |
| qry_pend | output | 1 | Pending bit of `qry_vec` |
| qry_insvc | output | 1 | In-service bit of `qry_vec` |
| qry_level | output | 1 | Trigger bit of `qry_vec` |

## Verification
A wrong bit in the pending map shows up in the cycle after the faulty edge. It appears on `qry_pend`, and on `irq` or `ack_vec` whenever that bit is or should be the highest one. A wrong in-service bit can stay hidden until it becomes the highest one in service. At that point `ppr` jumps to the wrong class, and the following end-of-interrupt retires the wrong vector. A corrupted task priority or enable bit shows at once on `tpr_short`, `ppr` or `irq`. The bench therefore compares all combinational outputs after every cycle of a long mixed sequence, so a divergence is caught within a cycle of becoming visible.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    localparam int DEF_VEC_W = 8;
    localparam int DEF_CLS_W = 4;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/irq_prio_find.sv
// Highest-numbered set bit of a map, with an explicit "nothing found" flag.
module irq_prio_find #(
    parameter int N = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  map_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (map_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ppr_calc.sv
// Processor priority from task priority and highest in-service vector.
module irq_ppr_calc #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4,
    localparam int SUB_W = VEC_W - CLS_W
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_hit_i,
    input  logic [VEC_W-1:0] isr_idx_i,
    output logic [VEC_W-1:0] ppr_o
);
    logic [CLS_W-1:0] tpr_cls;
    logic [CLS_W-1:0] isr_cls;

    assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
    assign isr_cls = isr_idx_i[VEC_W-1 -: CLS_W];

    always_comb begin
        if (!isr_hit_i || (tpr_cls >= isr_cls))
            ppr_o = tpr_i;
        else
            ppr_o = {isr_cls, {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/irq_accept_core.sv
module irq_accept_core #(
    parameter int VEC_W = irq_accept_pkg::DEF_VEC_W,
    parameter int CLS_W = irq_accept_pkg::DEF_CLS_W,
    localparam int NVEC  = 1 << VEC_W,
    localparam int SUB_W = VEC_W - CLS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             ack_stb,
    input  logic             eoi_stb,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             tpr_short_wr,
    input  logic [CLS_W-1:0] tpr_short_wdata,
    input  logic             svr_wr,
    input  logic [VEC_W:0]   svr_wdata,
    input  logic [VEC_W-1:0] qry_vec,
    output logic             irq,
    output logic [VEC_W-1:0] ack_vec,
    output logic [VEC_W-1:0] ppr,
    output logic [CLS_W-1:0] tpr_short,
    output logic             qry_pend,
    output logic             qry_insvc,
    output logic             qry_level
);
    import irq_accept_pkg::*;

    // registered state
    logic [NVEC-1:0]  pend_q, isr_q, trig_q;
    logic [VEC_W-1:0] tpr_q;
    logic [VEC_W:0]   svr_q;

    // next state
    logic [NVEC-1:0]  pend_n, isr_n, trig_n;
    logic [VEC_W-1:0] tpr_n;
    logic [VEC_W:0]   svr_n;

    logic             pend_hit, isr_hit;
    logic [VEC_W-1:0] pend_idx, isr_idx;
    logic             sw_en;
    logic             ack_spur;
    trig_e            set_trig;

    assign sw_en    = svr_q[VEC_W];
    assign set_trig = set_level ? TRIG_LEVEL : TRIG_EDGE;

    irq_prio_find #(.N(NVEC)) u_pend_find (
        .map_i (pend_q),
        .hit_o (pend_hit),
        .idx_o (pend_idx)
    );

    irq_prio_find #(.N(NVEC)) u_isr_find (
        .map_i (isr_q),
        .hit_o (isr_hit),
        .idx_o (isr_idx)
    );

    irq_ppr_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
        .tpr_i     (tpr_q),
        .isr_hit_i (isr_hit),
        .isr_idx_i (isr_idx),
        .ppr_o     (ppr)
    );

    // outputs
    always_comb begin
        ack_spur  = !pend_hit || !sw_en || ((tpr_q != '0) && (pend_idx <= tpr_q));
        ack_vec   = ack_spur ? svr_q[VEC_W-1:0] : pend_idx;
        irq       = sw_en && pend_hit &&
                    !((ppr != '0) && (pend_idx[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]));
        tpr_short = tpr_q[VEC_W-1 -: CLS_W];
        qry_pend  = pend_q[qry_vec];
        qry_insvc = isr_q[qry_vec];
        qry_level = trig_q[qry_vec];
    end

    // next-state: end-of-interrupt, then acknowledge, then set
    always_comb begin
        pend_n = pend_q;
        isr_n  = isr_q;
        trig_n = trig_q;
        tpr_n  = tpr_q;
        svr_n  = svr_q;
        if (eoi_stb && isr_hit)
            isr_n[isr_idx] = 1'b0;
        if (ack_stb && !ack_spur) begin
            pend_n[pend_idx] = 1'b0;
            isr_n[pend_idx]  = 1'b1;
        end
        if (set_stb) begin
            pend_n[set_vec] = 1'b1;
            trig_n[set_vec] = (set_trig == TRIG_LEVEL);
        end
        if (tpr_wr)
            tpr_n = tpr_wdata;
        else if (tpr_short_wr)
            tpr_n = {tpr_short_wdata, {SUB_W{1'b0}}};
        if (svr_wr)
            svr_n = svr_wdata;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            isr_q  <= '0;
            trig_q <= '0;
            tpr_q  <= '0;
            svr_q  <= {1'b0, {VEC_W{1'b1}}};
        end else begin
            pend_q <= pend_n;
            isr_q  <= isr_n;
            trig_q <= trig_n;
            tpr_q  <= tpr_n;
            svr_q  <= svr_n;
        end
    end
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
    parameter int VEC_W = 8,
    parameter int NVEC  = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set_stb,
    input logic             ack_stb,
    input logic             eoi_stb,
    input logic             irq,
    input logic [VEC_W-1:0] ack_vec,
    input logic             ack_spur,
    input logic             sw_en,
    input logic [NVEC-1:0]  pend_q,
    input logic [NVEC-1:0]  isr_q,
    input logic [VEC_W-1:0] tpr_q,
    input logic [VEC_W-1:0] ppr
);
    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sw_en && (pend_q != '0)));

    a_r5_spurious_keeps_maps: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && ack_spur && !set_stb && !eoi_stb) |=> ($stable(pend_q) && $stable(isr_q)));

    a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !ack_spur) |=> isr_q[$past(ack_vec)]);

    a_r7_ack_leaves_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !ack_spur && !set_stb) |=> !pend_q[$past(ack_vec)]);

    a_r8_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && (isr_q != '0) && !ack_stb) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    a_r10_ppr_not_below_tpr: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);
endmodule

bind irq_accept_core irq_accept_checker #(.VEC_W(VEC_W), .NVEC(NVEC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_stb  (set_stb),
    .ack_stb  (ack_stb),
    .eoi_stb  (eoi_stb),
    .irq      (irq),
    .ack_vec  (ack_vec),
    .ack_spur (ack_spur),
    .sw_en    (sw_en),
    .pend_q   (pend_q),
    .isr_q    (isr_q),
    .tpr_q    (tpr_q),
    .ppr      (ppr)
);

// File: tb/irq_accept_core_tb_top.sv
`timescale 1ns/1ps
module irq_accept_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       set_stb, set_level, ack_stb, eoi_stb, tpr_wr, tpr_short_wr, svr_wr;
    logic [7:0] set_vec, tpr_wdata, qry_vec;
    logic [3:0] tpr_short_wdata;
    logic [8:0] svr_wdata;
    logic       irq, qry_pend, qry_insvc, qry_level;
    logic [7:0] ack_vec, ppr;
    logic [3:0] tpr_short;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    logic [255:0] m_pend, m_isr, m_trig;
    logic [7:0]   m_tpr;
    logic [8:0]   m_svr;

    always #10 clk = ~clk;

    irq_accept_core dut_i (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_vec(set_vec),
        .set_level(set_level), .ack_stb(ack_stb), .eoi_stb(eoi_stb),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .tpr_short_wr(tpr_short_wr),
        .tpr_short_wdata(tpr_short_wdata), .svr_wr(svr_wr), .svr_wdata(svr_wdata),
        .qry_vec(qry_vec), .irq(irq), .ack_vec(ack_vec), .ppr(ppr),
        .tpr_short(tpr_short), .qry_pend(qry_pend), .qry_insvc(qry_insvc),
        .qry_level(qry_level)
    );

    function automatic int top_bit(input logic [255:0] m);
        for (int i = 255; i >= 0; i--) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_ppr();
        int h = top_bit(m_isr);
        logic [7:0] hv = 8'(h);
        if (h < 0 || m_tpr[7:4] >= hv[7:4]) return m_tpr;
        return {hv[7:4], 4'h0};
    endfunction

    function automatic logic exp_spur();
        int h = top_bit(m_pend);
        return (h < 0) || !m_svr[8] || (m_tpr != 0 && h <= int'(m_tpr));
    endfunction

    function automatic logic [7:0] exp_ack();
        return exp_spur() ? m_svr[7:0] : 8'(top_bit(m_pend));
    endfunction

    function automatic logic exp_irq();
        int h = top_bit(m_pend);
        logic [7:0] hv = 8'(h);
        logic [7:0] p = exp_ppr();
        return m_svr[8] && (h >= 0) && !(p != 0 && hv[7:4] <= p[7:4]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        set_stb = 0; set_level = 0; ack_stb = 0; eoi_stb = 0;
        tpr_wr = 0; tpr_short_wr = 0; svr_wr = 0;
        set_vec = 0; tpr_wdata = 0; tpr_short_wdata = 0; svr_wdata = 0;
    endtask

    // model update in R12 order: end-of-interrupt, acknowledge, set
    task automatic model_step();
        int hi_isr = top_bit(m_isr);
        int hi_pnd = top_bit(m_pend);
        logic spur = exp_spur();
        if (eoi_stb && hi_isr >= 0) m_isr[hi_isr] = 1'b0;
        if (ack_stb && !spur) begin
            m_pend[hi_pnd] = 1'b0;
            m_isr[hi_pnd]  = 1'b1;
        end
        if (set_stb) begin
            m_pend[set_vec] = 1'b1;
            m_trig[set_vec] = set_level;
        end
        if (tpr_wr) m_tpr = tpr_wdata;
        else if (tpr_short_wr) m_tpr = {tpr_short_wdata, 4'h0};
        if (svr_wr) m_svr = svr_wdata;
    endtask

    // inputs already driven after a negedge; runs one clock and checks outputs
    task automatic cycle(input logic full_check);
        #1;
        if (ack_stb) chk("R7 ack_vec", ack_vec, exp_ack());
        @(posedge clk);
        model_step();
        @(negedge clk);
        idle_inputs();
        qry_vec = 8'($urandom);
        #1;
        if (full_check) begin
            chk("R4 irq", irq, exp_irq());
            chk("R10 ppr", ppr, exp_ppr());
            chk("R9 tpr_short", tpr_short, m_tpr[7:4]);
            chk("R1 qry_pend", qry_pend, m_pend[qry_vec]);
            chk("R7 qry_insvc", qry_insvc, m_isr[qry_vec]);
            chk("R1 qry_level", qry_level, m_trig[qry_vec]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_pend = '0; m_isr = '0; m_trig = '0; m_tpr = 0; m_svr = 9'h0FF;
    endtask

    task automatic do_set(input logic [7:0] v, input logic lvl);
        set_stb = 1; set_vec = v; set_level = lvl; cycle(1);
    endtask

    task automatic do_svr(input logic [8:0] v);
        svr_wr = 1; svr_wdata = v; cycle(1);
    endtask

    task automatic do_tpr(input logic [7:0] v);
        tpr_wr = 1; tpr_wdata = v; cycle(1);
    endtask

    task automatic look(input logic [7:0] v);
        qry_vec = v; #1;
    endtask

    initial begin
        #4_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd2024);
        idle_inputs();
        qry_vec = 0;
        rst_n = 0;
        do_reset();

        // R11 reset state
        #1;
        chk("R11 irq after reset", irq, 0);
        chk("R11 ppr after reset", ppr, 0);
        chk("R11 ack_vec after reset", ack_vec, 8'hFF);
        chk("R11 tpr_short after reset", tpr_short, 0);
        look(8'h80);
        chk("R11 pending clear", qry_pend, 0);

        // R1 trigger bit
        do_set(8'h40, 1);
        look(8'h40);
        chk("R1 level trigger", qry_level, 1);
        chk("R1 pending set", qry_pend, 1);
        do_set(8'h40, 0);
        look(8'h40);
        chk("R1 edge trigger", qry_level, 0);

        // R3 enable gates irq; R6 disabled ack returns spurious
        chk("R3 irq low while disabled", irq, 0);
        ack_stb = 1; #1;
        chk("R6 ack while disabled", ack_vec, 8'hFF);
        cycle(1);
        look(8'h40);
        chk("R6 disabled ack no effect", qry_pend, 1);
        do_svr(9'h1A5);
        chk("R3 irq high once enabled", irq, 1);

        // R2 highest-numbered wins
        do_set(8'h90, 0);
        do_set(8'h55, 1);
        #1;
        chk("R2 highest pending", ack_vec, 8'h90);
        ack_stb = 1; cycle(1);
        ack_stb = 1; cycle(1);
        ack_stb = 1; cycle(1);
        // R8 end-of-interrupt retires highest only
        chk("R10 ppr from in-service", ppr, 8'h90);
        eoi_stb = 1; cycle(1);
        look(8'h90);
        chk("R8 highest retired", qry_insvc, 0);
        look(8'h55);
        chk("R8 lower kept", qry_insvc, 1);
        eoi_stb = 1; cycle(1);
        eoi_stb = 1; cycle(1);
        eoi_stb = 1; cycle(1);
        look(8'h40);
        chk("R8 eoi with none in service", qry_insvc, 0);
        // R6 nothing pending
        #1;
        chk("R6 nothing pending", ack_vec, 8'hA5);

        // R9 short write
        tpr_short_wr = 1; tpr_short_wdata = 4'hA; cycle(1);
        chk("R9 short read", tpr_short, 4'hA);
        chk("R9 low nibble zero", ppr, 8'hA0);

        // R4 class suppression
        do_tpr(8'h50);
        do_set(8'h5F, 0);
        chk("R4 equal class masked", irq, 0);
        do_set(8'h60, 0);
        chk("R4 higher class passes", irq, 1);

        // R5 spurious under task priority
        do_reset();
        do_svr(9'h13F);
        do_set(8'h62, 0);
        do_tpr(8'h62);
        #1;
        chk("R5 masked ack spurious", ack_vec, 8'h3F);
        ack_stb = 1; cycle(1);
        look(8'h62);
        chk("R5 still pending", qry_pend, 1);
        chk("R5 not in service", qry_insvc, 0);

        // R12 same-cycle ordering
        tpr_wr = 1; tpr_wdata = 8'h20; tpr_short_wr = 1; tpr_short_wdata = 4'h9; cycle(1);
        chk("R12 full write wins", tpr_short, 4'h2);
        ack_stb = 1; set_stb = 1; set_vec = 8'h62; cycle(1);
        look(8'h62);
        chk("R12 ack and set pending", qry_pend, 1);
        chk("R12 ack and set in service", qry_insvc, 1);

        // constrained random
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom % 16);
            if (r < 6) begin
                set_stb = 1; set_vec = 8'($urandom); set_level = 1'($urandom);
            end else if (r < 9) begin
                ack_stb = 1;
            end else if (r < 11) begin
                eoi_stb = 1;
            end else if (r == 11) begin
                tpr_wr = 1; tpr_wdata = 8'($urandom);
            end else if (r == 12) begin
                tpr_short_wr = 1; tpr_short_wdata = 4'($urandom);
            end else if (r == 13) begin
                svr_wr = 1; svr_wdata = {($urandom % 8) != 0, 8'($urandom)};
            end else if (r == 14) begin
                ack_stb = 1; eoi_stb = 1'($urandom);
                set_stb = 1; set_vec = 8'($urandom); set_level = 1'($urandom);
            end
            cycle(1);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule